// File: doc/BRIEF.md
# Speculative Load Ordering Guard

This block lets an out-of-order core issue loads early and still present sequentially consistent memory behaviour to other agents. Each load takes a queue slot in program order when it is dispatched and receives the slot index on `alloc_id`. When the load has executed, the core reports it through `exec_valid`/`exec_id`. From then on the load is exposed: the block compares every write or upgrade address seen on the coherent bus with the cache line of each exposed load. A match marks that load as stale.

Loads leave the queue oldest first. The core raises `commit_req` for the head load. If the head is unmarked, `commit_ok` answers in the same cycle and the slot is freed at the clock edge. If the head is marked, `flush` answers instead. The core must then discard that load and every younger instruction and fetch them again. The queue empties at that edge. Conflicts are rare, so this coarse recovery is sufficient.

Top module: `ldq_snoop_guard`

## Requirements
- R1: After synchronous reset the queue is empty: `full`, `commit_ok` and `flush` are low and `alloc_id` is 0.
- R2: An accepted allocation takes slot `alloc_id`, and `alloc_id` then advances by one modulo DEPTH, so slots are handed out in program order 0,1,2,3,0,...
- R3: With DEPTH loads held, `full` is high and an allocation request is ignored; the occupancy does not change.
- R4: A snoop marks every valid executed entry whose cache line (address bits [ADDR_W-1:OFS_W], with OFS_W=2 by default) equals the snoop's line; the offset bits [OFS_W-1:0] take no part in the comparison.
- R5: An entry that has not executed is never marked. An execute report in the same cycle as the snoop counts as executed.
- R6: A commit request on an unmarked head raises `commit_ok` in the same cycle with `flush` low, and the head slot is freed at that edge.
- R7: A commit request on a marked head raises `flush` in the same cycle with `commit_ok` low. At that edge all entries are dropped and the head and tail return to slot 0.
- R8: A snoop that hits the head in the same cycle as a commit request on it makes that commit a flush.
- R9: A commit request on an empty queue raises neither `commit_ok` nor `flush`.
- R10: A snoop to a different cache line leaves every entry unmarked.
- R11: An allocation requested in a flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request a slot for a new load |
| alloc_addr | input | ADDR_W | Byte address of the new load |
| alloc_id | output | IDX_W | Slot the next accepted load takes |
| full | output | 1 | All slots are taken; allocation stalls |
| exec_valid | input | 1 | A load has executed |
| exec_id | input | IDX_W | Slot of the executed load |
| snoop_valid | input | 1 | Remote write or upgrade observed |
| snoop_addr | input | ADDR_W | Address of the observed write or upgrade |
| commit_req | input | 1 | Request to retire the head load |
| commit_ok | output | 1 | Head retires normally |
| flush | output | 1 | Head is stale; flush and re-execute |

## Verification
`commit_ok` and `flush` are combinational answers to `commit_req` and are due in the same cycle. The bench drives each request shortly after a rising edge and samples these outputs before the next edge. A mark set by a snoop is visible from the cycle after the snoop, or in the same cycle when the snoop hits the head. Freed slots, the cleared queue after a flush and the advance of `alloc_id` are visible one edge after the request, so the bench reads `full` and `alloc_id` after that edge. The sweeps cover every subset of marked slots and every subset of executed slots in a four-entry queue, and the bench derives the expected first flush position from the subset.

// File: rtl/ldq_pkg.sv
package ldq_pkg;
    parameter int LQ_ADDR_W = 16;
    parameter int LQ_OFS_W  = 2;
    localparam int LQ_LINE_W = LQ_ADDR_W - LQ_OFS_W;

    typedef logic [LQ_LINE_W-1:0] line_t;

    typedef struct packed {
        logic  valid;
        logic  done;
        logic  stale;
        line_t line;
    } lq_entry_t;

    function automatic line_t line_of(input logic [LQ_ADDR_W-1:0] a);
        return a[LQ_ADDR_W-1:LQ_OFS_W];
    endfunction
endpackage

// File: rtl/ldq_ptr_ctrl.sv
module ldq_ptr_ctrl #(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [IDX_W:0]   occ,
    output logic             full
);
    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            if (push) tail <= bump(tail);
            if (pop)  head <= bump(head);
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    assign full = (occ == (IDX_W+1)'(DEPTH));
endmodule

// File: rtl/ldq_slot.sv
module ldq_slot
    import ldq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      fill,
    input  line_t     fill_line,
    input  logic      exec_hit,
    input  logic      retire,
    input  logic      snoop_valid,
    input  line_t     snoop_line,
    output lq_entry_t ent,
    output logic      snoop_hit
);
    assign snoop_hit = snoop_valid && ent.valid && (ent.done || exec_hit)
                       && (ent.line == snoop_line);

    always_ff @(posedge clk) begin
        if (rst || clear || retire) begin
            ent <= '0;
        end else if (fill) begin
            ent.valid <= 1'b1;
            ent.done  <= 1'b0;
            ent.stale <= 1'b0;
            ent.line  <= fill_line;
        end else begin
            if (exec_hit && ent.valid) ent.done  <= 1'b1;
            if (snoop_hit)             ent.stale <= 1'b1;
        end
    end
endmodule

// File: rtl/ldq_commit_judge.sv
module ldq_commit_judge
    import ldq_pkg::*;
(
    input  lq_entry_t head_ent,
    input  logic      head_snoop_hit,
    input  logic      commit_req,
    output logic      commit_ok,
    output logic      flush
);
    logic live;
    logic stale_now;

    always_comb begin
        live      = commit_req && head_ent.valid;
        stale_now = head_ent.stale || head_snoop_hit;
        commit_ok = live && !stale_now;
        flush     = live && stale_now;
    end
endmodule

// File: rtl/ldq_snoop_guard.sv
module ldq_snoop_guard
    import ldq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int ADDR_W = LQ_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    output logic [IDX_W-1:0]  alloc_id,
    output logic              full,
    input  logic              exec_valid,
    input  logic [IDX_W-1:0]  exec_id,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              commit_req,
    output logic              commit_ok,
    output logic              flush
);
    logic [IDX_W-1:0] head;
    logic [IDX_W-1:0] tail;
    logic [IDX_W:0]   occ;
    logic             push;
    lq_entry_t        ents [DEPTH];
    logic [DEPTH-1:0] hits;
    line_t            alloc_line;
    line_t            snoop_line;

    assign alloc_line = line_of(alloc_addr);
    assign snoop_line = line_of(snoop_addr);
    assign push       = alloc_valid && !full && !flush;
    assign alloc_id   = tail;

    ldq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .push (push),
        .pop  (commit_ok),
        .clear(flush),
        .head (head),
        .tail (tail),
        .occ  (occ),
        .full (full)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        ldq_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .clear      (flush),
            .fill       (push && (tail == IDX_W'(i))),
            .fill_line  (alloc_line),
            .exec_hit   (exec_valid && (exec_id == IDX_W'(i))),
            .retire     (commit_ok && (head == IDX_W'(i))),
            .snoop_valid(snoop_valid),
            .snoop_line (snoop_line),
            .ent        (ents[i]),
            .snoop_hit  (hits[i])
        );
    end

    ldq_commit_judge u_judge (
        .head_ent      (ents[head]),
        .head_snoop_hit(hits[head]),
        .commit_req    (commit_req),
        .commit_ok     (commit_ok),
        .flush         (flush)
    );
endmodule

// File: rtl/ldq_snoop_guard_chk.sv
module ldq_snoop_guard_chk #(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic           clk,
    input logic           rst,
    input logic           alloc_valid,
    input logic           full,
    input logic           commit_ok,
    input logic           flush,
    input logic [IDX_W:0] occ
);
    AST_OK_FLUSH_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(commit_ok && flush)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= (IDX_W+1)'(DEPTH)); // R3
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
        (full && alloc_valid && !commit_ok && !flush) |=> (occ == $past(occ))); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (occ == '0)); // R11
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> (!commit_ok && !flush)); // R9
    AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
        (commit_ok && !alloc_valid) |=> (occ == $past(occ) - 1'b1)); // R6
    AST_PUSH_ONE: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !full && !flush && !commit_ok) |=> (occ == $past(occ) + 1'b1)); // R2
endmodule

bind ldq_snoop_guard ldq_snoop_guard_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .alloc_valid(alloc_valid),
    .full       (full),
    .commit_ok  (commit_ok),
    .flush      (flush),
    .occ        (occ)
);

// File: tb/sim_ldq_snoop_guard.sv
`timescale 1ns/1ps
module sim_ldq_snoop_guard;
    localparam int DEPTH = 4;
    localparam int IDX_W = 2;
    localparam int AW    = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          alloc_valid;
    logic [AW-1:0] alloc_addr;
    logic [IDX_W-1:0] alloc_id;
    logic          full;
    logic          exec_valid;
    logic [IDX_W-1:0] exec_id;
    logic          snoop_valid;
    logic [AW-1:0] snoop_addr;
    logic          commit_req;
    logic          commit_ok;
    logic          flush;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    ldq_snoop_guard #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
        .alloc_id(alloc_id), .full(full),
        .exec_valid(exec_valid), .exec_id(exec_id),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .commit_req(commit_req), .commit_ok(commit_ok), .flush(flush)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        alloc_valid = 0; alloc_addr = '0; exec_valid = 0; exec_id = '0;
        snoop_valid = 0; snoop_addr = '0; commit_req = 0;
    endtask

    task automatic step();
        @(posedge clk); #1; quiet();
    endtask

    function automatic logic [AW-1:0] addr_of(input int line, input int ofs);
        return AW'((line << 2) | (ofs & 3));
    endfunction

    task automatic alloc(input int line, input int exp_id);
        alloc_valid = 1; alloc_addr = addr_of(line, exp_id);
        #1 chk(alloc_id == IDX_W'(exp_id), "R2 slot order", alloc_id, exp_id);
        step();
    endtask

    task automatic commit_seq(input int mask, input string tag);
        int k = DEPTH;
        for (int b = DEPTH - 1; b >= 0; b--) if (mask[b]) k = b;
        for (int c = 0; c < DEPTH; c++) begin
            commit_req = 1;
            #1;
            if (c < k) begin
                chk(commit_ok && !flush, "R6 unmarked head commits", {commit_ok, flush}, 2);
                step();
            end else begin
                chk(flush && !commit_ok, tag, {commit_ok, flush}, 1);
                alloc_valid = 1; alloc_addr = addr_of(7, 0);
                step();
                chk(!full && alloc_id == 0, "R7 flush clears queue", {full, alloc_id}, 0);
                commit_req = 1;
                #1 chk(!commit_ok && !flush, "R11 alloc in flush dropped", {commit_ok, flush}, 0);
                step();
                break;
            end
        end
        if (k == DEPTH) begin
            commit_req = 1;
            #1 chk(!commit_ok && !flush, "R9 empty commit quiet", {commit_ok, flush}, 0);
            step();
        end
    endtask

    initial begin
        #20000;
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        quiet();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        chk(!full && !commit_ok && !flush && alloc_id == 0, "R1 reset state",
            {full, commit_ok, flush, alloc_id}, 0);

        // Sweep of snoop-hit subsets: R4 marks, R10 other line ignored, R3 full stall
        for (int m = 0; m < 16; m++) begin
            for (int i = 0; i < DEPTH; i++) alloc(16 + i, i);
            chk(full == 1, "R3 full after DEPTH loads", full, 1);
            alloc_valid = 1; alloc_addr = addr_of(40, 0);
            step();
            chk(full == 1 && alloc_id == 0, "R3 alloc while full ignored", {full, alloc_id}, 4);
            for (int i = 0; i < DEPTH; i++) begin
                exec_valid = 1; exec_id = IDX_W'(i); step();
            end
            snoop_valid = 1; snoop_addr = addr_of(48, m); step();   // R10
            for (int i = 0; i < DEPTH; i++) if (m[i]) begin
                snoop_valid = 1; snoop_addr = addr_of(16 + i, m + i); step();
            end
            commit_seq(m, "R4 marked head flushes");
        end

        // Sweep of executed subsets: R5 unexecuted loads not marked; slot 3 executes with the snoop
        for (int e = 0; e < 16; e++) begin
            for (int i = 0; i < DEPTH; i++) alloc(32 + i, i);
            for (int i = 0; i < DEPTH - 1; i++) if (e[i]) begin
                exec_valid = 1; exec_id = IDX_W'(i); step();
            end
            for (int i = 0; i < DEPTH; i++) begin
                snoop_valid = 1; snoop_addr = addr_of(32 + i, 3);
                if (i == DEPTH - 1 && e[i]) begin exec_valid = 1; exec_id = IDX_W'(i); end
                step();
            end
            commit_seq(e, "R5 only executed loads marked");
        end

        // R8: snoop to head and commit in the same cycle
        alloc(5, 0);
        alloc(6, 1);
        exec_valid = 1; exec_id = 0; step();
        snoop_valid = 1; snoop_addr = addr_of(5, 2); commit_req = 1;
        #1 chk(flush && !commit_ok, "R8 same-cycle snoop flushes", {commit_ok, flush}, 1);
        step();
        chk(alloc_id == 0 && !full, "R7 pointers reset after flush", alloc_id, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule